// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block rebuilds a processor's control bus from a compressed three-bit status code. At every rising clock edge it samples the status code. When the code leaves the passive value, a new bus cycle begins. The block then produces the following outputs on the clock that follows:

- an address-latch pulse;
- separate memory and I/O read and write commands, plus an interrupt acknowledge;
- early write strobes;
- a data-buffer enable and a data-direction line;
- one dual-purpose output whose meaning is set by a mode pin.

The processor returns the status to passive to end the cycle. All commands drop on the clock after that.

Two enable inputs gate the commands at the pins:

- A command enable gates every command.
- An active-low address enable blocks the memory commands only.

In system-bus mode, the dual-purpose output is a cascade enable for an interrupt controller. In I/O-bus mode, it enables the I/O data transceivers and the I/O commands no longer depend on the command enable.

Top module: `busCmdGen`

## Requirements
- R1: After reset every command output, `ale`, `dataEn` and `cascPerEn` are low and `dtXmit` is high.
- R2: When the status sampled at an edge is non-passive and the previous cycle was idle (passive), a new bus cycle starts. Its first clock is T1. `ale` is high for exactly that one clock, except when the code is halt (011), which raises no `ale`.
- R3: The status codes are decoded as follows: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. Code fetch and memory read both drive `memRd`. Halt drives no command. A read command or `intAck` is high from T2, the second clock of the cycle, until the cycle ends.
- R4: For a write cycle, the early strobe (`memWrEarly` or `ioWrEarly`) rises in T2. The normal strobe (`memWr` or `ioWr`) rises one clock later, in T3. Both stay high until the cycle ends.
- R5: Sampling the passive code 111 ends the cycle. On the next clock all commands and `dataEn` are low and `dtXmit` is high, even if the passive code arrives during T1. A change to a different non-passive code in the middle of a cycle does not change the cycle type.
- R6: `dtXmit` is low (receive) from T1 to the end of a read, code-fetch or interrupt-acknowledge cycle. It is high at all other times.
- R7: `dataEn` is high from T2 to the end of every cycle except halt. The one exception is I/O cycles in I/O-bus mode (see R11).
- R8: While `cmdEn` is low, no command output is high. The one exception is I/O commands in I/O-bus mode (see R11).
- R9: While `addrEnN` is high, `memRd`, `memWr` and `memWrEarly` are low. The I/O commands and `intAck` are unaffected.
- R10: In system-bus mode (`ioBusMode` = 0), `cascPerEn` is high only during T1 of an interrupt-acknowledge cycle.
- R11: In I/O-bus mode (`ioBusMode` = 1), `cascPerEn` is high from T2 to the end of I/O read and I/O write cycles. In this mode `dataEn` stays low for those I/O cycles, and the I/O commands ignore `cmdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busStatus | input | 3 | Status code from the processor |
| addrEnN | input | 1 | Active-low enable for memory commands |
| cmdEn | input | 1 | Enable for all command outputs |
| ioBusMode | input | 1 | 1 selects I/O-bus mode, 0 selects system-bus mode |
| memRd | output | 1 | Memory read command |
| memWr | output | 1 | Normal memory write command |
| memWrEarly | output | 1 | Early memory write command |
| ioRd | output | 1 | I/O read command |
| ioWr | output | 1 | Normal I/O write command |
| ioWrEarly | output | 1 | Early I/O write command |
| intAck | output | 1 | Interrupt acknowledge |
| ale | output | 1 | Address latch strobe |
| dataEn | output | 1 | Data buffer enable |
| dtXmit | output | 1 | Data direction, 1 = transmit, 0 = receive |
| cascPerEn | output | 1 | Cascade enable or peripheral data enable, chosen by mode |

## Verification
The status is registered once. Every cycle-phase output (`ale`, `dtXmit`, and `cascPerEn` in system-bus mode) is therefore due one clock after the edge that samples the first non-passive code. Reads, early writes and `dataEn` are due one clock later, and normal writes one clock after that. Every output drops one clock after the edge that samples the passive code. The enable inputs act without a clock delay.

The bench changes the inputs on the falling edge. It advances a behavioural cycle counter on each rising edge. It compares every output on the next falling edge, before it changes anything. This way each latency is checked on the exact cycle in which the result is due, and gating takes effect in the same cycle it is applied.

// File: rtl/busCmdPkg.sv
package busCmdPkg;
  localparam int STATUS_W = 3;

  localparam logic [STATUS_W-1:0] ST_INTA  = 3'b000;
  localparam logic [STATUS_W-1:0] ST_IORD  = 3'b001;
  localparam logic [STATUS_W-1:0] ST_IOWR  = 3'b010;
  localparam logic [STATUS_W-1:0] ST_HALT  = 3'b011;
  localparam logic [STATUS_W-1:0] ST_FETCH = 3'b100;
  localparam logic [STATUS_W-1:0] ST_MEMRD = 3'b101;
  localparam logic [STATUS_W-1:0] ST_MEMWR = 3'b110;
  localparam logic [STATUS_W-1:0] ST_IDLE  = 3'b111;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } busPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                active;
    logic                inT1;
    logic                fromT2;
    logic                fromT3;
    logic [STATUS_W-1:0] cycType;
  } ctlStrobes_t;
endpackage

// File: rtl/busCmdCtl.sv
module busCmdCtl
  import busCmdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] busStatus,
  output ctlStrobes_t         strobes
);
  busPhase_t           phase, phaseNext;
  logic [STATUS_W-1:0] typeReg, typeNext;

  always_comb begin
    phaseNext = phase;
    typeNext  = typeReg;
    if (busStatus == ST_IDLE) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext = PH_T1;
          typeNext  = busStatus;
        end
        PH_T1:   phaseNext = PH_T2;
        PH_T2:   phaseNext = PH_T3;
        PH_T3:   phaseNext = PH_T3;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      typeReg <= ST_IDLE;
    end else begin
      phase   <= phaseNext;
      typeReg <= typeNext;
    end
  end

  always_comb begin
    strobes.active  = (phase != PH_IDLE);
    strobes.inT1    = (phase == PH_T1);
    strobes.fromT2  = (phase == PH_T2) || (phase == PH_T3);
    strobes.fromT3  = (phase == PH_T3);
    strobes.cycType = typeReg;
  end

  // R5: passive code at an edge leaves the block idle afterwards
  assert_passive_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busStatus == ST_IDLE) |=> !strobes.active);

  // R2: T1 lasts a single clock
  assert_t1_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inT1 |=> !strobes.inT1);

  // R5: cycle type is held while a cycle runs
  assert_type_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && busStatus != ST_IDLE) |=> $stable(strobes.cycType));
endmodule

// File: rtl/busCmdDp.sv
module busCmdDp
  import busCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        addrEnN,
  input  logic        cmdEn,
  input  logic        ioBusMode,
  output logic        memRd,
  output logic        memWr,
  output logic        memWrEarly,
  output logic        ioRd,
  output logic        ioWr,
  output logic        ioWrEarly,
  output logic        intAck,
  output logic        ale,
  output logic        dataEn,
  output logic        dtXmit,
  output logic        cascPerEn
);
  logic isInta, isIoRd, isIoWr, isHalt, isMemRd, isMemWr;
  logic isIo, isRead;
  logic rawMemRd, rawMemWr, rawMemWrEarly;
  logic rawIoRd, rawIoWr, rawIoWrEarly, rawIntAck;
  logic memGate, ioGate, ackGate;

  always_comb begin
    isInta  = (strobes.cycType == ST_INTA);
    isIoRd  = (strobes.cycType == ST_IORD);
    isIoWr  = (strobes.cycType == ST_IOWR);
    isHalt  = (strobes.cycType == ST_HALT);
    isMemRd = (strobes.cycType == ST_FETCH) || (strobes.cycType == ST_MEMRD);
    isMemWr = (strobes.cycType == ST_MEMWR);
    isIo    = isIoRd || isIoWr;
    isRead  = isInta || isIoRd || isMemRd;
  end

  always_comb begin
    rawMemRd      = strobes.fromT2 && isMemRd;
    rawMemWrEarly = strobes.fromT2 && isMemWr;
    rawMemWr      = strobes.fromT3 && isMemWr;
    rawIoRd       = strobes.fromT2 && isIoRd;
    rawIoWrEarly  = strobes.fromT2 && isIoWr;
    rawIoWr       = strobes.fromT3 && isIoWr;
    rawIntAck     = strobes.fromT2 && isInta;
  end

  always_comb begin
    memGate = cmdEn && !addrEnN;
    ioGate  = cmdEn || ioBusMode;
    ackGate = cmdEn;
  end

  always_comb begin
    memRd      = rawMemRd      && memGate;
    memWr      = rawMemWr      && memGate;
    memWrEarly = rawMemWrEarly && memGate;
    ioRd       = rawIoRd       && ioGate;
    ioWr       = rawIoWr       && ioGate;
    ioWrEarly  = rawIoWrEarly  && ioGate;
    intAck     = rawIntAck     && ackGate;
  end

  always_comb begin
    ale    = strobes.inT1 && !isHalt;
    dtXmit = !(strobes.active && isRead);
    dataEn = strobes.fromT2 && !isHalt && !(ioBusMode && isIo);
    if (ioBusMode) cascPerEn = strobes.fromT2 && isIo;
    else           cascPerEn = strobes.inT1 && isInta;
  end

  // R2: address strobe never lasts longer than one clock
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R4: normal write rises only after the early write was already up
  assert_mem_wr_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawMemWr) |-> $past(rawMemWrEarly));
  assert_io_wr_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawIoWr) |-> $past(rawIoWrEarly));

  // R9: memory commands are blocked by the address enable
  assert_addr_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    addrEnN |-> !(memRd || memWr || memWrEarly));

  // R8: command enable low in system-bus mode blocks everything
  assert_cmd_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdEn && !ioBusMode) |-> !(memRd || memWr || memWrEarly || ioRd || ioWr || ioWrEarly || intAck));

  // R3: at most one read or early strobe at a time
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, ioRd, intAck, memWrEarly, ioWrEarly}));

  // R6: receive direction never coincides with a write strobe
  assert_dir_R6: assert property (@(posedge clk) disable iff (!rstN)
    !dtXmit |-> !(memWr || ioWr || memWrEarly || ioWrEarly));
endmodule

// File: rtl/busCmdGen.sv
module busCmdGen
  import busCmdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] busStatus,
  input  logic                addrEnN,
  input  logic                cmdEn,
  input  logic                ioBusMode,
  output logic                memRd,
  output logic                memWr,
  output logic                memWrEarly,
  output logic                ioRd,
  output logic                ioWr,
  output logic                ioWrEarly,
  output logic                intAck,
  output logic                ale,
  output logic                dataEn,
  output logic                dtXmit,
  output logic                cascPerEn
);
  ctlStrobes_t strobes;

  busCmdCtl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .busStatus (busStatus),
    .strobes   (strobes)
  );

  busCmdDp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .addrEnN    (addrEnN),
    .cmdEn      (cmdEn),
    .ioBusMode  (ioBusMode),
    .memRd      (memRd),
    .memWr      (memWr),
    .memWrEarly (memWrEarly),
    .ioRd       (ioRd),
    .ioWr       (ioWr),
    .ioWrEarly  (ioWrEarly),
    .intAck     (intAck),
    .ale        (ale),
    .dataEn     (dataEn),
    .dtXmit     (dtXmit),
    .cascPerEn  (cascPerEn)
  );
endmodule

// File: tb/tb_busCmdGen.sv
module tb_busCmdGen;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] busStatus;
  logic       addrEnN, cmdEn, ioBusMode;
  logic memRd, memWr, memWrEarly, ioRd, ioWr, ioWrEarly, intAck;
  logic ale, dataEn, dtXmit, cascPerEn;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";

  // reference model state: 0 idle, 1 = T1, 2 = T2, 3 = T3 and beyond
  int modelPhase = 0;
  int modelType  = 7;

  always #2 clk = ~clk;

  busCmdGen dut (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .addrEnN(addrEnN),
    .cmdEn(cmdEn), .ioBusMode(ioBusMode), .memRd(memRd), .memWr(memWr),
    .memWrEarly(memWrEarly), .ioRd(ioRd), .ioWr(ioWr), .ioWrEarly(ioWrEarly),
    .intAck(intAck), .ale(ale), .dataEn(dataEn), .dtXmit(dtXmit),
    .cascPerEn(cascPerEn)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelPhase <= 0;
      modelType  <= 7;
    end else if (busStatus == 3'b111) begin
      modelPhase <= 0;
    end else if (modelPhase == 0) begin
      modelPhase <= 1;
      modelType  <= int'(busStatus);
    end else if (modelPhase < 3) begin
      modelPhase <= modelPhase + 1;
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit halt, rdLike, io, memTy, wrMem;
    bit eMemRd, eMemWr, eMemWrE, eIoRd, eIoWr, eIoWrE, eAck;
    bit eAle, eDen, eDt, eCasc;
    halt   = (modelType == 3);
    rdLike = (modelType == 0) || (modelType == 1) || (modelType == 4) || (modelType == 5);
    io     = (modelType == 1) || (modelType == 2);
    memTy  = (modelType == 4) || (modelType == 5);
    wrMem  = (modelType == 6);
    eMemRd  = (modelPhase >= 2) && memTy && cmdEn && !addrEnN;
    eMemWrE = (modelPhase >= 2) && wrMem && cmdEn && !addrEnN;
    eMemWr  = (modelPhase >= 3) && wrMem && cmdEn && !addrEnN;
    eIoRd   = (modelPhase >= 2) && (modelType == 1) && (cmdEn || ioBusMode);
    eIoWrE  = (modelPhase >= 2) && (modelType == 2) && (cmdEn || ioBusMode);
    eIoWr   = (modelPhase >= 3) && (modelType == 2) && (cmdEn || ioBusMode);
    eAck    = (modelPhase >= 2) && (modelType == 0) && cmdEn;
    eAle    = (modelPhase == 1) && !halt;
    eDt     = !((modelPhase > 0) && rdLike);
    eDen    = (modelPhase >= 2) && !halt && !(ioBusMode && io);
    eCasc   = ioBusMode ? ((modelPhase >= 2) && io) : ((modelPhase == 1) && (modelType == 0));
    chk(curReq, "memRd", memRd, eMemRd);
    chk(curReq, "memWr", memWr, eMemWr);
    chk(curReq, "memWrEarly", memWrEarly, eMemWrE);
    chk(curReq, "ioRd", ioRd, eIoRd);
    chk(curReq, "ioWr", ioWr, eIoWr);
    chk(curReq, "ioWrEarly", ioWrEarly, eIoWrE);
    chk(curReq, "intAck", intAck, eAck);
    chk("R2", "ale", ale, eAle);
    chk("R6", "dtXmit", dtXmit, eDt);
    chk(ioBusMode ? "R11" : "R7", "dataEn", dataEn, eDen);
    chk(ioBusMode ? "R11" : "R10", "cascPerEn", cascPerEn, eCasc);
  endtask

  // compare the current outputs, then drive the next status
  task automatic tick(input logic [2:0] st);
    @(negedge clk);
    checkAll();
    busStatus = st;
  endtask

  task automatic busCycle(input logic [2:0] code, input int len);
    for (int i = 0; i < len; i++) tick(code);
    tick(3'b111);
    tick(3'b111);
  endtask

  initial begin
    int dog = 0;
    while (dog < 20000) begin
      @(posedge clk);
      dog++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; busStatus = 3'b000;
    addrEnN = 1'b0; cmdEn = 1'b1; ioBusMode = 1'b0;
    repeat (2) @(negedge clk);
    // R1: idle state after reset, even with non-passive status present
    curReq = "R1";
    checkAll();
    busStatus = 3'b111;
    @(negedge clk);
    rstN = 1'b1;
    tick(3'b111);

    curReq = "R3";
    busCycle(3'b101, 5);
    busCycle(3'b100, 4);
    busCycle(3'b001, 5);
    busCycle(3'b000, 5);
    busCycle(3'b011, 5);

    curReq = "R4";
    busCycle(3'b110, 6);
    busCycle(3'b010, 6);

    // R5: early end during T1 and during T2
    curReq = "R5";
    busCycle(3'b110, 1);
    busCycle(3'b101, 2);
    // R5: mid-cycle code change does not alter the cycle type
    tick(3'b110); tick(3'b110); tick(3'b001); tick(3'b001); tick(3'b000);
    tick(3'b111); tick(3'b111);
    // back-to-back cycles separated by one passive clock
    tick(3'b010); tick(3'b010); tick(3'b010); tick(3'b111);
    tick(3'b101); tick(3'b101); tick(3'b111); tick(3'b111);

    // R8: command enable low blocks everything in system-bus mode
    curReq = "R8";
    cmdEn = 1'b0;
    busCycle(3'b101, 4);
    busCycle(3'b010, 5);
    busCycle(3'b000, 4);
    // toggle command enable in the middle of a write
    tick(3'b110); tick(3'b110); tick(3'b110);
    cmdEn = 1'b1;
    tick(3'b110); tick(3'b110);
    cmdEn = 1'b0;
    tick(3'b111); tick(3'b111);
    cmdEn = 1'b1;

    // R9: address enable blocks memory commands only
    curReq = "R9";
    addrEnN = 1'b1;
    busCycle(3'b110, 5);
    busCycle(3'b100, 4);
    busCycle(3'b001, 4);
    busCycle(3'b000, 4);
    addrEnN = 1'b0;

    // R10: cascade enable in T1 of interrupt acknowledge
    curReq = "R10";
    busCycle(3'b000, 3);
    busCycle(3'b001, 3);

    // R11: I/O-bus mode behaviour
    curReq = "R11";
    ioBusMode = 1'b1;
    busCycle(3'b001, 4);
    busCycle(3'b010, 5);
    busCycle(3'b101, 4);
    busCycle(3'b000, 4);
    cmdEn = 1'b0;
    busCycle(3'b010, 5);
    busCycle(3'b001, 4);
    busCycle(3'b110, 4);
    cmdEn = 1'b1;
    ioBusMode = 1'b0;

    // R1: asynchronous reset in the middle of a cycle
    curReq = "R1";
    tick(3'b110); tick(3'b110); tick(3'b110);
    rstN = 1'b0;
    tick(3'b111);
    rstN = 1'b1;
    tick(3'b111);
    tick(3'b111);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule